// File: doc/BRIEF.md
# Synchronous Rectifier Mode Supervisor

This block decides, once per clock, which operating mode a secondary-side synchronous rectifier controller is in. It also decides whether the gate timing logic may drive the rectifier switch. It sees only digital flags. Two supply flags come from separate comparators, one for the turn-on level and one for the lower lockout level, which gives hysteresis. It also sees an enable level, the positive-crossing reset comparator, and a per-cycle report from the minimum-on-time timer: a strobe when the timer expires, together with the value of the turn-off comparator at that moment.

After power-up, or after waking from sleep, the gate is held off until the sensed drain-source voltage first crosses the positive reset level. This stops the controller from starting in the middle of a conduction interval. Once that happens, the gate stays permitted. A conduction interval shorter than the minimum on time moves the block into a protection mode, which blocks the next gate pulse. The timing logic keeps evaluating each cycle with the gate held low. The first cycle that outlasts the minimum on time brings the block back to normal operation without any outside help.

Top module: `rect_mode_sup`

## Requirements
- R1: After reset the mode output is 2'b00 (lockout) and gate_permit is 0. The block stays in lockout while vcc_ok_on is 0.
- R2: In lockout, with vcc_ok_on high and vcc_low_uvlo low, the next cycle's mode is 2'b10 (normal) if enable is high, or 2'b01 (sleep) if enable is low.
- R3: vcc_low_uvlo high forces mode 2'b00 on the next cycle from any mode. It takes priority over every other input.
- R4: With both supply flags low, the mode is held. Lockout does not leave, and normal does not drop.
- R5: After entering normal mode, gate_permit stays 0 until vds_pos_reset is seen high while in normal or protection mode. gate_permit becomes 1 on the following cycle.
- R6: In normal mode, mot_done together with mot_vds_high moves the block to protection (2'b11) on the next cycle, and gate_permit drops to 0. mot_done with mot_vds_high low leaves normal mode unchanged.
- R7: In protection mode, mot_done with mot_vds_high low returns the block to normal on the next cycle. gate_permit comes back without a new crossing. mot_done with mot_vds_high high, and vds_pos_reset, leave protection mode in place.
- R8: enable low in normal or protection mode gives sleep (2'b01) on the next cycle, even if a minimum-on-time report arrives in the same cycle. In sleep, gate_permit is 0 and vds_pos_reset has no effect. enable high returns the block to normal.
- R9: Each entry to normal from sleep or lockout needs a fresh positive crossing before gate_permit rises.
- R10: gate_permit is 1 only while the mode output is 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_ok_on | input | 1 | Supply is above the turn-on level |
| vcc_low_uvlo | input | 1 | Supply is below the lockout level |
| enable | input | 1 | Enable level; low requests sleep |
| vds_pos_reset | input | 1 | Drain-source voltage is above the positive reset level |
| mot_done | input | 1 | One-cycle strobe at the end of the minimum on time |
| mot_vds_high | input | 1 | Turn-off comparator output sampled with mot_done |
| gate_permit | output | 1 | Gate timing logic may drive the switch |
| mode | output | 2 | 00 lockout, 01 sleep, 10 normal, 11 protection |

## Verification
The bench targets the hysteresis band with both supply flags low. A design that compared against a single level would drop out of normal mode, or leave lockout too early. It checks that wake-up from sleep needs a fresh positive crossing. A design that kept its activation flag would drive the gate partway through a cycle. It also checks recovery from protection without a new crossing, and that pos-reset pulses seen during sleep are ignored. Priority collisions are covered too: lockout against a minimum-on report, enable-low against recovery, and both supply flags high at once. A wrong priority order shows up as the wrong mode code one cycle later.

// File: rtl/rect_mode_sup_pkg.sv
package rect_mode_sup_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_LOCK  = 2'b00,
        MODE_SLEEP = 2'b01,
        MODE_NORM  = 2'b10,
        MODE_PROT  = 2'b11
    } sup_mode_e;

    typedef struct packed {
        logic supply_low;
        logic supply_on;
        logic enable;
        logic mot_done;
        logic mot_high;
    } sup_in_t;

    function automatic sup_mode_e next_mode(input sup_mode_e cur, input sup_in_t in);
        sup_mode_e nxt;
        nxt = cur;
        if (in.supply_low) begin
            nxt = MODE_LOCK;
        end else begin
            unique case (cur)
                MODE_LOCK:  if (in.supply_on) nxt = in.enable ? MODE_NORM : MODE_SLEEP;
                MODE_SLEEP: if (in.enable) nxt = MODE_NORM;
                MODE_NORM: begin
                    if (!in.enable) nxt = MODE_SLEEP;
                    else if (in.mot_done && in.mot_high) nxt = MODE_PROT;
                end
                MODE_PROT: begin
                    if (!in.enable) nxt = MODE_SLEEP;
                    else if (in.mot_done && !in.mot_high) nxt = MODE_NORM;
                end
                default: nxt = MODE_LOCK;
            endcase
        end
        return nxt;
    endfunction

    function automatic logic mode_active(input sup_mode_e m);
        return (m == MODE_NORM) || (m == MODE_PROT);
    endfunction

endpackage

// File: rtl/rms_mode_reg.sv
module rms_mode_reg
    import rect_mode_sup_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sup_in_t   ins,
    output sup_mode_e mode_q
);
    sup_mode_e mode_d;

    always_comb mode_d = next_mode(mode_q, ins);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_LOCK;
        else     mode_q <= mode_d;
    end
endmodule

// File: rtl/rms_arm_latch.sv
module rms_arm_latch
    import rect_mode_sup_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sup_mode_e mode_q,
    input  logic      pos_cross,
    output logic      armed_q
);
    always_ff @(posedge clk) begin
        if (rst)                       armed_q <= 1'b0;
        else if (!mode_active(mode_q)) armed_q <= 1'b0;
        else if (pos_cross)            armed_q <= 1'b1;
    end
endmodule

// File: rtl/rect_mode_sup.sv
module rect_mode_sup
    import rect_mode_sup_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vcc_ok_on,
    input  logic              vcc_low_uvlo,
    input  logic              enable,
    input  logic              vds_pos_reset,
    input  logic              mot_done,
    input  logic              mot_vds_high,
    output logic              gate_permit,
    output logic [MODE_W-1:0] mode
);
    sup_in_t   ins;
    sup_mode_e mode_q;
    logic      armed_q;

    always_comb begin
        ins.supply_low = vcc_low_uvlo;
        ins.supply_on  = vcc_ok_on;
        ins.enable     = enable;
        ins.mot_done   = mot_done;
        ins.mot_high   = mot_vds_high;
    end

    rms_mode_reg u_mode (
        .clk    (clk),
        .rst    (rst),
        .ins    (ins),
        .mode_q (mode_q)
    );

    rms_arm_latch u_arm (
        .clk       (clk),
        .rst       (rst),
        .mode_q    (mode_q),
        .pos_cross (vds_pos_reset),
        .armed_q   (armed_q)
    );

    assign gate_permit = armed_q && (mode_q == MODE_NORM);
    assign mode        = mode_q;
endmodule

// File: rtl/rms_check.sv
module rms_check
    import rect_mode_sup_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              vcc_ok_on,
    input logic              vcc_low_uvlo,
    input logic              enable,
    input logic              vds_pos_reset,
    input logic              mot_done,
    input logic              mot_vds_high,
    input logic              gate_permit,
    input logic [MODE_W-1:0] mode
);
    // R3
    lockout_entry_chk: assert property (@(posedge clk) disable iff (rst)
        vcc_low_uvlo |=> mode == MODE_LOCK);

    // R4
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LOCK && !vcc_ok_on) |=> mode == MODE_LOCK);

    // R6
    short_cond_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_NORM && mot_done && mot_vds_high && !vcc_low_uvlo && enable)
        |=> (mode == MODE_PROT && !gate_permit));

    // R7
    recover_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PROT && mot_done && !mot_vds_high && !vcc_low_uvlo && enable)
        |=> mode == MODE_NORM);

    // R8
    sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (!enable && !vcc_low_uvlo && (mode == MODE_NORM || mode == MODE_PROT))
        |=> (mode == MODE_SLEEP && !gate_permit));

    // R5
    permit_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_permit) |-> ($past(vds_pos_reset) || $past(mode) == MODE_PROT));
endmodule

bind rect_mode_sup rms_check u_chk (
    .clk           (clk),
    .rst           (rst),
    .vcc_ok_on     (vcc_ok_on),
    .vcc_low_uvlo  (vcc_low_uvlo),
    .enable        (enable),
    .vds_pos_reset (vds_pos_reset),
    .mot_done      (mot_done),
    .mot_vds_high  (mot_vds_high),
    .gate_permit   (gate_permit),
    .mode          (mode)
);

// File: tb/rect_mode_sup_test.sv
module rect_mode_sup_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vcc_ok_on = 1'b0, vcc_low_uvlo = 1'b0, enable = 1'b0;
    logic vds_pos_reset = 1'b0, mot_done = 1'b0, mot_vds_high = 1'b0;
    logic gate_permit;
    logic [1:0] mode;
    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    rect_mode_sup uut (
        .clk(clk), .rst(rst), .vcc_ok_on(vcc_ok_on), .vcc_low_uvlo(vcc_low_uvlo),
        .enable(enable), .vds_pos_reset(vds_pos_reset), .mot_done(mot_done),
        .mot_vds_high(mot_vds_high), .gate_permit(gate_permit), .mode(mode)
    );

    always #2 clk = ~clk;

    // Vector fields: {low, on, en, pos, mot_done, mot_high, exp_mode[1:0], exp_permit}
    localparam int NV = 27;
    localparam logic [8:0] VEC [NV] = '{
        9'b000000_00_0, // R1 no turn-on flag: stay lockout
        9'b001000_00_0, // R1 R4 enable alone is not enough
        9'b011000_10_0, // R2 enter normal
        9'b001000_10_0, // R4 hysteresis band holds normal
        9'b001000_10_0, // R5 waiting for crossing
        9'b001100_10_1, // R5 crossing arms gate
        9'b001000_10_1, // R10 stays permitted
        9'b001010_10_1, // R6 long conduction keeps normal
        9'b001011_11_0, // R6 short conduction -> protection
        9'b001000_11_0, // R7 holds protection
        9'b001100_11_0, // R7 crossing does not leave protection
        9'b001011_11_0, // R7 short again stays
        9'b001010_10_1, // R7 recovery, permit without new crossing
        9'b000000_01_0, // R8 enable low -> sleep
        9'b000100_01_0, // R8 crossing ignored in sleep
        9'b001000_10_0, // R9 wake needs fresh crossing
        9'b001100_10_1, // R9 crossing re-arms
        9'b111000_00_0, // R3 lockout wins over turn-on flag
        9'b001000_00_0, // R4 band holds lockout
        9'b010000_01_0, // R2 supply ok, enable low -> sleep
        9'b100000_00_0, // R3 sleep -> lockout
        9'b011011_10_0, // R2 R9 report in lockout ignored, no arm
        9'b011011_11_0, // R6 short report from unarmed normal
        9'b000010_01_0, // R8 enable low beats recovery
        9'b011000_10_0, // R8 enable high returns to normal
        9'b011011_11_0, // R6 to protection
        9'b101010_00_0  // R3 lockout beats recovery
    };

    task automatic check(input string req, input logic [1:0] em, input logic ep);
        checks++;
        if (mode !== em || gate_permit !== ep) begin
            fails++;
            $display("FAIL %s: mode=%b permit=%b expected mode=%b permit=%b",
                     req, mode, gate_permit, em, ep);
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset", 2'b00, 1'b0);
        for (int i = 0; i < NV; i++) begin
            {vcc_low_uvlo, vcc_ok_on, enable, vds_pos_reset, mot_done, mot_vds_high} = VEC[i][8:3];
            @(negedge clk);
            check($sformatf("vector %0d", i), VEC[i][2:1], VEC[i][0]);
        end
        // R1 reset from an armed normal state
        {vcc_low_uvlo, vcc_ok_on, enable, vds_pos_reset, mot_done, mot_vds_high} = 6'b011000;
        @(negedge clk);
        vds_pos_reset = 1'b1;
        @(negedge clk);
        vds_pos_reset = 1'b0;
        @(negedge clk);
        check("R5 armed before reset", 2'b10, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-run", 2'b00, 1'b0);
        rst = 1'b0;
        vcc_ok_on = 1'b0;
        @(negedge clk);
        check("R1 stays lockout after reset", 2'b00, 1'b0);
        // R9 lockout-to-normal does not inherit the old activation
        vcc_ok_on = 1'b1;
        @(negedge clk);
        check("R9 fresh entry unarmed", 2'b10, 1'b0);
        done = 1'b1;
        finish_run();
    end
endmodule